// File: doc/BRIEF.md
# Interrupt Polarity Inverter Bank

This block sits in front of an interrupt controller that only understands active-high levels and rising edges. It takes 256 interrupt lines from peripherals. For each line it either passes the line through unchanged or inverts it, so that a peripheral with an active-low level output, or with a falling-edge output, can still be served.

Each line has one polarity bit. The bits are grouped into eight 32-bit configuration words. These words sit in a 0x200-byte register window behind a simple synchronous read/write port.

Each output is registered on the block clock. Edge detection, masking, priority and acknowledge are all left to the downstream controller.

Top module: `irq_polarity_bank`

## Requirements
- R1: Each output bit is the input bit XOR its polarity bit. Both values are sampled at a clock edge, and the result appears on `irqOut` after that edge, which gives one cycle of latency.
- R2: A polarity bit of 1 inverts its line, so a low input gives a high output and a falling input gives a rising output. A polarity bit of 0 passes the line through unchanged.
- R3: While `rstN` is low, every polarity bit, `irqOut` and `busRdata` clear to zero at the clock edge.
- R4: Line n is controlled by bit (n mod 32) of the word at byte offset 0x04 + 4*(n/32). The mapped words are therefore 0x04 through 0x20.
- R5: A write (`busSel`=1, `busWr`=1) to a mapped offset stores all 32 bits of `busWdata` at the clock edge. A read (`busSel`=1, `busWr`=0) loads the addressed word into `busRdata` at the clock edge. `busRdata` holds its value when no read is made.
- R6: The following accesses are unmapped: offset 0x00, every offset from 0x24 up to 0x1FC, and every address with `busAddr[1:0]` not equal to 0. Reads of an unmapped access return zero, and writes to it change no polarity bit.
- R7: A write made at clock edge k changes `irqOut` only at edge k+1. Just after edge k, `irqOut` still reflects the old polarity.
- R8: Software can save and restore the settings. It reads all eight words, overwrites them, then writes the saved values back. After this, every line again has exactly the inversion it had before.
- R9: Flipping one polarity bit while its input is held steady produces exactly one transition on that output bit. No other output bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| busSel | input | 1 | Access strobe for the register window |
| busWr | input | 1 | 1 selects a write, 0 selects a read |
| busAddr | input | 9 | Byte offset within the 0x200 window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irqIn | input | 256 | Raw peripheral interrupt lines |
| irqOut | output | 256 | Lines after polarity correction, registered |

## Verification
The checker tests four things on every cycle:
- The registered XOR relation between `irqIn`, the polarity bits and `irqOut`.
- The cleared state right after reset.
- That any unmapped write leaves the polarity bits untouched, and that any unmapped read returns zero.
- That each mapped write lands in the right word.

Three properties need whole sequences of stimulus, so only the bench scenarios can show them:
- The exact line-to-bit mapping, seen through real inverted inputs.
- The two-edge delay from a write to the output.
- The save-and-restore round trip, and the single output edge caused by flipping one bit.

// File: rtl/irq_pol_pkg.sv
package irq_pol_pkg;
  localparam int LINES     = 256;
  localparam int WORD_W    = 32;
  localparam int WORDS     = LINES / WORD_W;
  localparam int IDX_W     = $clog2(WORDS);
  localparam int ADDR_W    = 9;
  localparam int BASE_WORD = 1;   // first configuration word sits at byte 0x04

  typedef struct packed {
    logic             rdEn;
    logic             rdHit;
    logic [IDX_W-1:0] idx;
    logic [WORDS-1:0] wrWord;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_pol_ctrl.sv
module irq_pol_ctrl
  import irq_pol_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strb
);
  localparam int WOFF_W = ADDR_W - 2;

  logic [WOFF_W-1:0] wordOff;
  logic [WOFF_W-1:0] relOff;
  logic              aligned;
  logic              inRange;

  always_comb begin
    wordOff = busAddr[ADDR_W-1:2];
    aligned = (busAddr[1:0] == 2'b00);
    relOff  = wordOff - WOFF_W'(BASE_WORD);
    inRange = aligned && (wordOff >= WOFF_W'(BASE_WORD)) && (relOff < WOFF_W'(WORDS));
  end

  assign strb.rdEn  = busSel && !busWr;
  assign strb.rdHit = inRange;
  assign strb.idx   = relOff[IDX_W-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_wrDec
    assign strb.wrWord[w] = busSel && busWr && inRange && (relOff == WOFF_W'(w));
  end
endmodule

// File: rtl/irq_pol_dp.sv
module irq_pol_dp
  import irq_pol_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [LINES-1:0]  irqIn,
  output logic [LINES-1:0]  irqOut,
  output logic [WORD_W-1:0] busRdata,
  output logic [LINES-1:0]  cfgFlat
);
  logic [WORD_W-1:0] cfgWord [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)               cfgWord[w] <= '0;
      else if (strb.wrWord[w]) cfgWord[w] <= busWdata;
    end
    assign cfgFlat[w*WORD_W +: WORD_W] = cfgWord[w];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= irqIn ^ cfgFlat;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (strb.rdEn) busRdata <= strb.rdHit ? cfgWord[strb.idx] : '0;
  end
endmodule

// File: rtl/irq_polarity_bank.sv
module irq_polarity_bank
  import irq_pol_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic [LINES-1:0]  irqIn,
  output logic [LINES-1:0]  irqOut
);
  ctrlStrobe_t      strb;
  logic [LINES-1:0] cfgFlat;

  irq_pol_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  irq_pol_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWdata(busWdata),
    .irqIn   (irqIn),
    .irqOut  (irqOut),
    .busRdata(busRdata),
    .cfgFlat (cfgFlat)
  );
endmodule

// File: rtl/irq_pol_chk.sv
module irq_pol_chk
  import irq_pol_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WORD_W-1:0] busWdata,
  input logic [WORD_W-1:0] busRdata,
  input logic [LINES-1:0]  irqIn,
  input logic [LINES-1:0]  irqOut,
  input logic [LINES-1:0]  cfgFlat
);
  logic [ADDR_W-3:0] wo;
  logic              mapped;
  logic              pendValid;
  logic [IDX_W-1:0]  pendIdx;
  logic [WORD_W-1:0] pendData;
  logic [WORD_W-1:0] selWord;

  always_comb begin
    wo      = busAddr[ADDR_W-1:2];
    mapped  = (busAddr[1:0] == 2'b00) && (int'(wo) >= BASE_WORD) && (int'(wo) < BASE_WORD + WORDS);
    selWord = cfgFlat[int'(pendIdx)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendIdx   <= '0;
      pendData  <= '0;
    end else begin
      pendValid <= busSel && busWr && mapped;
      pendIdx   <= IDX_W'(int'(wo) - BASE_WORD);
      pendData  <= busWdata;
    end
  end

  // R1, R2
  assert_xor_out_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> irqOut == ($past(irqIn) ^ $past(cfgFlat)));
  // R3
  assert_reset_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cfgFlat == '0 && irqOut == '0 && busRdata == '0));
  // R6
  assert_unmapped_wr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !mapped) |=> $stable(cfgFlat));
  assert_unmapped_rd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && !mapped) |=> busRdata == '0);
  // R4, R5
  assert_word_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> selWord == pendData);
endmodule

bind irq_polarity_bank irq_pol_chk u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .irqOut(irqOut),
  .cfgFlat(cfgFlat)
);

// File: tb/irq_polarity_bank_tb.sv
module irq_polarity_bank_tb;
  import irq_pol_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [WORD_W-1:0] busWdata = '0;
  logic [WORD_W-1:0] busRdata;
  logic [LINES-1:0]  irqIn = '0;
  logic [LINES-1:0]  irqOut;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [WORD_W-1:0] model [WORDS];
  logic [WORD_W-1:0] saved [WORDS];

  always #10 clk = ~clk;   // 50 MHz

  irq_polarity_bank u_dut (.*);

  function automatic bit isMapped(logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b00) && (a >= 9'h004) && (a <= 9'h020);
  endfunction

  function automatic logic [LINES-1:0] modelFlat();
    logic [LINES-1:0] f;
    for (int w = 0; w < WORDS; w++) f[w*WORD_W +: WORD_W] = model[w];
    return f;
  endfunction

  task automatic check(bit ok, string req, logic [LINES-1:0] act, logic [LINES-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    if (isMapped(a)) model[(a >> 2) - 1] = d;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [WORD_W-1:0] rd;
    logic [LINES-1:0]  prevOut;
    int edges;
    void'($urandom(32'h5EED_1234));
    for (int w = 0; w < WORDS; w++) model[w] = '0;
    irqIn = {8{32'hA5A5_5A5A}};
    repeat (3) @(negedge clk);
    // R3: cleared outputs during reset
    check(irqOut == '0 && busRdata == '0, "R3", irqOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: zero polarity passes input through after one edge
    check(irqOut == irqIn, "R1", irqOut, irqIn);

    // R1 latency: new input visible only after one edge
    irqIn = '1;
    #1 check(irqOut == {8{32'hA5A5_5A5A}}, "R1", irqOut, {8{32'hA5A5_5A5A}});
    @(negedge clk);
    check(irqOut == '1, "R1", irqOut, '1);

    // R4, R2: line 37 lives in word 0x08 bit 5; active-low line becomes active-high
    irqIn = '1;
    irqIn[37] = 1'b0;
    busWrite(9'h008, 32'h0000_0020);
    @(negedge clk);
    check(irqOut[37] == 1'b1 && irqOut[36] == 1'b1, "R4", irqOut, '1);
    irqIn[37] = 1'b1;   // falling request removed -> output must fall (inverted)
    @(negedge clk);
    check(irqOut[37] == 1'b0, "R2", irqOut, {~irqIn[255:38], 1'b0, irqIn[36:0]});
    // R4: top line 255 is bit 31 of word 0x20
    busWrite(9'h020, 32'h8000_0000);
    @(negedge clk);
    check(irqOut[255] == 1'b0 && irqOut[254] == 1'b1, "R4", irqOut, irqIn ^ modelFlat());

    // R7: write effect delay
    irqIn = '0;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 9'h004; busWdata = 32'h0000_0001;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; model[0] = 32'h1;
    check(irqOut[0] == 1'b0, "R7", irqOut, '0);
    @(negedge clk);
    check(irqOut[0] == 1'b1, "R7", irqOut, modelFlat());

    // R6: unmapped write/read
    busWrite(9'h000, 32'hFFFF_FFFF);
    busWrite(9'h024, 32'hFFFF_FFFF);
    busWrite(9'h1FC, 32'hFFFF_FFFF);
    busWrite(9'h005, 32'hFFFF_FFFF);
    @(negedge clk);
    check(irqOut == modelFlat(), "R6", irqOut, modelFlat());
    busRead(9'h000, rd); check(rd == '0, "R6", LINES'(rd), '0);
    busRead(9'h1FC, rd); check(rd == '0, "R6", LINES'(rd), '0);
    busRead(9'h009, rd); check(rd == '0, "R6", LINES'(rd), '0);

    // R5: full word readback and hold
    busWrite(9'h010, 32'hDEAD_BEEF);
    busRead(9'h010, rd);
    check(rd == 32'hDEAD_BEEF, "R5", LINES'(rd), LINES'(32'hDEAD_BEEF));
    repeat (3) @(negedge clk);
    check(busRdata == 32'hDEAD_BEEF, "R5", LINES'(busRdata), LINES'(32'hDEAD_BEEF));

    // R9: single edge from one bit flip with steady input
    irqIn = '0;
    for (int w = 0; w < WORDS; w++) busWrite(9'(4 + 4*w), 32'h0);
    repeat (2) @(negedge clk);
    prevOut = irqOut; edges = 0;
    busWrite(9'h004, 32'h0000_0020);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (irqOut[5] != prevOut[5]) edges++;
      check((irqOut & ~(LINES'(1) << 5)) == '0, "R9", irqOut, LINES'(1) << 5);
      prevOut = irqOut;
    end
    check(edges == 1 && irqOut[5], "R9", LINES'(edges), LINES'(1));

    // Random phase: R1, R2, R4, R5, R6
    for (int i = 0; i < 200; i++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom % 3 == 0) ? 9'($urandom) : 9'(4 + 4*($urandom % WORDS));
      busWrite(a, $urandom);
      for (int w = 0; w < WORDS; w++) irqIn[w*32 +: 32] = $urandom;
      repeat (2) @(negedge clk);
      check(irqOut == (irqIn ^ modelFlat()), "R1", irqOut, irqIn ^ modelFlat());
      a = 9'($urandom);
      busRead(a, rd);
      check(rd == (isMapped(a) ? model[(a >> 2) - 1] : '0), "R5", LINES'(rd),
            LINES'(isMapped(a) ? model[(a >> 2) - 1] : '0));
    end

    // R8: save, clobber, restore
    for (int w = 0; w < WORDS; w++) busRead(9'(4 + 4*w), saved[w]);
    for (int w = 0; w < WORDS; w++) busWrite(9'(4 + 4*w), ~saved[w]);
    for (int w = 0; w < WORDS; w++) busWrite(9'(4 + 4*w), saved[w]);
    for (int w = 0; w < WORDS; w++) begin
      busRead(9'(4 + 4*w), rd);
      check(rd == saved[w], "R8", LINES'(rd), LINES'(saved[w]));
    end
    irqIn = '0;
    repeat (2) @(negedge clk);
    check(irqOut == modelFlat(), "R8", irqOut, modelFlat());

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule